// File: doc/BRIEF.md
# Synchronous Serial Position Transmitter

This block is the clocked-slave output stage of an angle-measurement core. The core hands it a parallel position word, an output-width setting and an error flag. An external master supplies a serial clock and reads one serial data line. The block freezes the position and the error flag when a frame starts. It then shifts the position out most significant bit first, sends the error flag, and after that forwards whatever it has received on its serial data input. Several transmitters can therefore be chained into one long shift path. A transmitter whose output is wired back to its own input can also be read out cyclically.

All external inputs are sampled on the internal system clock through two-flop synchronisers. A frame starts on the first falling edge of the serial clock while the transmitter is armed. A quiet-time counter on the system clock ends the frame. It restarts on every serial clock edge. When it runs out, the transmitter arms itself again and the serial output returns high.

Top module: `ssi_pos_tx`

## Requirements
- R1: After reset the transmitter is armed and `sdo_o` is 1.
- R2: The first falling edge of `sclk_i` while armed captures `pos_i` and `err_i`. Changes to either input after that edge do not alter the frame.
- R3: `sdo_o` stays 1 between the capturing falling edge and the first rising edge. Each rising edge k (k = 1..W) then drives bit W-k of the captured position, plain binary, MSB first.
- R4: The frame width W is `width_i` clamped to 1..POS_W: 0 gives 1, and values above POS_W give POS_W. The width is taken only while armed. A change in the middle of a frame is ignored.
- R5: Rising edge W+1 drives the captured error flag.
- R6: Rising edge k > W+1 drives the level of `sdi_i` that was sampled at rising edge k-W-1. This is a pass-through delayed by W+1 bits.
- R7: With `sdo_o` looped back to `sdi_i`, rising edge W+2 drives a 1 (stop bit). After that the pattern position, error, stop repeats with period W+2.
- R8: A frame ends after IDLE_CYC consecutive system-clock cycles with no `sclk_i` edge. If the next edge is detected exactly IDLE_CYC cycles after the previous one, the frame continues. If it is detected one cycle later, the transmitter is armed again and that falling edge starts a new frame.
- R9: Falling edges of `sclk_i` inside a frame cause no new capture. Rising edges while armed are ignored.
- R10: When a frame ends, `sdo_o` returns to 1 and stays 1 while armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pos_i | input | POS_W | Position word from the core |
| err_i | input | 1 | Error flag from the core |
| width_i | input | SEL_W | Requested output width in bits (clamped to 1..POS_W) |
| sclk_i | input | 1 | External serial clock, idles high |
| sdi_i | input | 1 | Serial data input for chaining or loopback |
| sdo_o | output | 1 | Serial data output, idles high |

## Verification
The two functions that can coincide are the expiry of the quiet-time counter and the arrival of a new serial clock edge, in the same system-clock cycle. The bench sets this up by ending a short frame with the clock held high. It then drops the clock after a gap of exactly IDLE_CYC system cycles, and in a second run after IDLE_CYC+1 cycles. The position input is preset so that a fresh capture would send a 1 where the running frame would send a pass-through 0. The level seen at the next rising edge therefore shows which of the two took effect.

// File: rtl/ssi_tx_pkg.sv
// Shared types for the serial position transmitter.
package ssi_tx_pkg;

    // Transmitter state: waiting for a frame, or inside one.
    typedef enum logic {
        ST_ARMED = 1'b0,
        ST_FRAME = 1'b1
    } tx_state_e;

    // One-cycle edge pulses of the synchronised serial clock.
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

endpackage

// File: rtl/ssi_tx_sync.sv
// Multi-bit synchroniser chain.
// Assumes each bit is an independent slow level (no bus coherency needed).
// Reset loads INIT so idle-high lines do not produce a false edge.
module ssi_tx_sync #(
    parameter int            W      = 1,
    parameter int            STAGES = 2,
    parameter logic [W-1:0]  INIT   = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift the asynchronous levels through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= {STAGES{INIT}};
        end else begin
            stg <= {stg[STAGES-2:0], d};
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ssi_tx_edge.sv
// Edge detector for the synchronised serial clock.
// Assumes the input is already synchronous; the clock idles high, so the
// history flop resets to 1.
module ssi_tx_edge
    import ssi_tx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  lvl,
    output edge_t edg
);
    logic prev;

    // Remember the previous sampled level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= lvl;
    end

    assign edg.rise = lvl & ~prev;
    assign edg.fall = ~lvl & prev;
endmodule

// File: rtl/ssi_tx_ctrl.sv
// Frame control: armed/frame state and the quiet-time counter.
// A falling edge while armed opens a frame. In a frame every edge restarts
// the counter, and IDLE_CYC edge-free cycles close it. An edge detected in
// the cycle the counter would run out takes priority. Assumes IDLE_CYC >= 2.
module ssi_tx_ctrl
    import ssi_tx_pkg::*;
#(
    parameter int IDLE_CYC = 64
) (
    input  logic  clk,
    input  logic  rst_n,
    input  edge_t edg,
    output logic  armed,
    output logic  capture,
    output logic  shift_en,
    output logic  expire
);
    localparam int              CNT_W = $clog2(IDLE_CYC);
    localparam logic [CNT_W-1:0] LIM  = CNT_W'(IDLE_CYC - 1);

    tx_state_e        st;
    logic [CNT_W-1:0] quiet;
    logic             edge_any;

    assign edge_any = edg.rise | edg.fall;
    assign armed    = (st == ST_ARMED);
    assign capture  = armed & edg.fall;
    assign shift_en = ~armed & edg.rise;
    assign expire   = ~armed & ~edge_any & (quiet == LIM);

    // Advance the state and the quiet-time counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_ARMED;
            quiet <= '0;
        end else if (capture) begin
            st    <= ST_FRAME;
            quiet <= '0;
        end else if (armed || edge_any) begin
            quiet <= '0;
        end else if (expire) begin
            st    <= ST_ARMED;
            quiet <= '0;
        end else begin
            quiet <= quiet + 1'b1;
        end
    end
endmodule

// File: rtl/ssi_tx_shift.sv
// Output shifter. On capture it loads {position, error} so that the position
// MSB of the chosen width sits at index W. Each shift drives index W and
// moves the register up by one, with the serial input entering at bit 0.
// The serial input thus reappears W+1 shifts later. The width is sampled
// only while armed.
module ssi_tx_shift #(
    parameter int POS_W = 32,
    parameter int SEL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] pos,
    input  logic             err,
    input  logic [SEL_W-1:0] width_sel,
    input  logic             sdi,
    input  logic             armed,
    input  logic             capture,
    input  logic             shift_en,
    input  logic             expire,
    output logic             sdo,
    output logic [SEL_W-1:0] width_q
);
    localparam logic [SEL_W-1:0] MAXW = SEL_W'(POS_W);

    logic [POS_W:0]   frame_q;
    logic [SEL_W-1:0] width_c;

    // Clamp the requested width into 1..POS_W.
    always_comb begin
        if (width_sel == '0)       width_c = SEL_W'(1);
        else if (width_sel > MAXW) width_c = MAXW;
        else                       width_c = width_sel;
    end

    // Load, hold idle level, or shift one bit out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            width_q <= MAXW;
            sdo     <= 1'b1;
        end else if (capture) begin
            frame_q <= {pos, err};
            width_q <= width_c;
        end else if (armed) begin
            width_q <= width_c;
            sdo     <= 1'b1;
        end else if (expire) begin
            sdo     <= 1'b1;
        end else if (shift_en) begin
            sdo     <= frame_q[width_q];
            frame_q <= {frame_q[POS_W-1:0], sdi};
        end
    end
endmodule

// File: rtl/ssi_pos_tx.sv
// Top of the synchronous serial position transmitter.
// Synchronises the serial clock and data input, finds clock edges, runs the
// frame control and drives the output shifter. Assumes the serial clock
// half-period is longer than three system clocks and shorter than IDLE_CYC.
module ssi_pos_tx
    import ssi_tx_pkg::*;
#(
    parameter  int POS_W       = 32,
    parameter  int IDLE_CYC    = 64,
    parameter  int SYNC_STAGES = 2,
    localparam int SEL_W       = $clog2(POS_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] pos_i,
    input  logic             err_i,
    input  logic [SEL_W-1:0] width_i,
    input  logic             sclk_i,
    input  logic             sdi_i,
    output logic             sdo_o
);
    logic             sclk_s;
    logic             sdi_s;
    edge_t            edg;
    logic             sclk_rise;
    logic             sclk_fall;
    logic             armed;
    logic             capture;
    logic             shift_en;
    logic             expire;
    logic [SEL_W-1:0] width_q;

    ssi_tx_sync #(.W(2), .STAGES(SYNC_STAGES), .INIT(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk_i, sdi_i}),
        .q     ({sclk_s, sdi_s})
    );

    ssi_tx_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (sclk_s),
        .edg   (edg)
    );

    assign sclk_rise = edg.rise;
    assign sclk_fall = edg.fall;

    ssi_tx_ctrl #(.IDLE_CYC(IDLE_CYC)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .edg      (edg),
        .armed    (armed),
        .capture  (capture),
        .shift_en (shift_en),
        .expire   (expire)
    );

    ssi_tx_shift #(.POS_W(POS_W), .SEL_W(SEL_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .pos       (pos_i),
        .err       (err_i),
        .width_sel (width_i),
        .sdi       (sdi_s),
        .armed     (armed),
        .capture   (capture),
        .shift_en  (shift_en),
        .expire    (expire),
        .sdo       (sdo_o),
        .width_q   (width_q)
    );
endmodule

// File: rtl/ssi_pos_tx_chk.sv
// Property checker for ssi_pos_tx, attached by bind. Watches the frame
// state, the edge pulses, the latched width and the serial output.
module ssi_pos_tx_chk #(
    parameter int SEL_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             armed,
    input logic             sclk_rise,
    input logic             sclk_fall,
    input logic             expire,
    input logic             sdo_o,
    input logic [SEL_W-1:0] width_q
);
    // R10
    armed_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> sdo_o);

    // R2
    capture_opens_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_fall && armed) |=> !armed);

    // R9
    no_recapture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_fall && !armed) |=> !armed);

    // R4
    width_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && $past(!armed)) |-> $stable(width_q));

    // R3
    sdo_moves_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sdo_o) && !armed) |-> $past(sclk_rise));

    // R8
    rearm_by_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(expire));
endmodule

bind ssi_pos_tx ssi_pos_tx_chk #(.SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .armed     (armed),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .expire    (expire),
    .sdo_o     (sdo_o),
    .width_q   (width_q)
);

// File: tb/ssi_pos_tx_bench.sv
// Directed bench for ssi_pos_tx: one task per scenario, each self-checking.
module ssi_pos_tx_bench;
    localparam int POS_W    = 32;
    localparam int IDLE_CYC = 64;
    localparam int HALF     = 6;   // serial clock half-period in system clocks

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pos = '0;
    logic        err = 1'b0;
    logic [5:0]  width = 6'd32;
    logic        sclk = 1'b1;
    logic        sdi_reg = 1'b1;
    logic        loop = 1'b0;
    logic        sdi;
    logic        sdo;
    int          nchk = 0;
    int          nerr = 0;
    bit          done = 1'b0;

    assign sdi = loop ? sdo : sdi_reg;

    always #10 clk = ~clk;

    ssi_pos_tx #(.POS_W(POS_W), .IDLE_CYC(IDLE_CYC)) u_ssi_pos_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .pos_i   (pos),
        .err_i   (err),
        .width_i (width),
        .sclk_i  (sclk),
        .sdi_i   (sdi),
        .sdo_o   (sdo)
    );

    task automatic check(input logic got, input logic exp, input string req, input string what);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic tx_fall();
        @(negedge clk);
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic tx_rise(output logic b);
        @(negedge clk);
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        b = sdo;
    endtask

    task automatic quiet(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Frame with given width; inputs are disturbed after capture (R2, R4).
    task automatic do_frame(input logic [31:0] p, input logic e, input logic [5:0] wsel,
                            input int wexp, input int extra, input logic [63:0] dpat);
        logic b;
        logic x;
        pos = p; err = e; width = wsel; sdi_reg = dpat[0];
        tx_fall();
        check(sdo, 1'b1, "R3", "high before first rise");
        pos = ~p; err = ~e; width = 6'd3;
        for (int k = 1; k <= wexp + 1 + extra; k++) begin
            if (k > 1) begin
                sdi_reg = dpat[k-1];
                tx_fall();   // R9: falls inside the frame must not recapture
            end
            tx_rise(b);
            if (k <= wexp) begin
                x = p[wexp-k];
                check(b, x, "R3", $sformatf("position bit at edge %0d", k));
            end else if (k == wexp + 1) begin
                check(b, e, "R5", "error bit");
            end else begin
                x = dpat[k-wexp-2];
                check(b, x, "R6", $sformatf("pass-through at edge %0d", k));
            end
        end
        quiet(IDLE_CYC + 8);
        check(sdo, 1'b1, "R10", "idle high after frame");
    endtask

    task automatic t_reset();
        check(sdo, 1'b1, "R1", "output after reset");
    endtask

    task automatic t_full_width();
        do_frame(32'hA5C3_1E96, 1'b1, 6'd32, 32, 5, 64'h0000_0000_0000_0016);
    endtask

    task automatic t_narrow();
        do_frame(32'hFFFF_FF3C, 1'b0, 6'd8, 8, 6, 64'h0000_0000_0000_0029);
    endtask

    // R4: width 0 clamps to 1, width 40 clamps to 32.
    task automatic t_clamp();
        do_frame(32'h0000_0001, 1'b0, 6'd0, 1, 2, 64'h2);
        do_frame(32'h8000_0001, 1'b0, 6'd40, 32, 1, 64'h1);
    endtask

    // R7: loopback gives position, error, stop bit 1, repeating.
    task automatic t_loop();
        logic        outm [1:40];
        logic        inm;
        logic        b;
        logic [31:0] p = 32'h0000_0096;
        loop = 1'b1; pos = p; err = 1'b0; width = 6'd8;
        tx_fall();
        for (int k = 1; k <= 23; k++) begin
            if (k > 1) tx_fall();
            tx_rise(b);
            if (k <= 8) outm[k] = p[8-k];
            else if (k == 9) outm[k] = 1'b0;
            else begin
                inm = (k - 9 == 1) ? 1'b1 : outm[k-10];
                outm[k] = inm;
            end
            check(b, outm[k], "R7", $sformatf("loopback edge %0d", k));
        end
        loop = 1'b0;
        quiet(IDLE_CYC + 8);
        check(sdo, 1'b1, "R10", "idle high after loopback");
    endtask

    // R8: edge exactly at expiry keeps the frame; one cycle later re-arms.
    task automatic t_gap();
        logic b;
        pos = 32'h5; err = 1'b1; width = 6'd4; sdi_reg = 1'b0;
        tx_fall();
        for (int k = 1; k <= 5; k++) begin
            if (k > 1) tx_fall();
            tx_rise(b);
        end
        check(b, 1'b1, "R5", "error bit before gap");
        pos = 32'hF;
        quiet(IDLE_CYC - HALF - 1);
        tx_fall();
        tx_rise(b);
        check(b, 1'b0, "R8", "gap of IDLE_CYC keeps frame (pass-through 0)");
        quiet(IDLE_CYC + 1 - HALF - 1);
        tx_fall();
        tx_rise(b);
        check(b, 1'b1, "R8", "gap of IDLE_CYC+1 starts new frame (MSB 1)");
        quiet(IDLE_CYC + 8);
        check(sdo, 1'b1, "R10", "idle high after gap test");
    endtask

    // R9: rising edges while armed are ignored.
    task automatic t_armed_rise();
        tx_fall();
        quiet(IDLE_CYC + 8);
        check(sdo, 1'b1, "R9", "low clock while armed then frame ends");
        @(negedge clk);
        sclk = 1'b1;
        quiet(HALF);
        check(sdo, 1'b1, "R9", "rise while armed ignored");
    endtask

    initial begin
        quiet(5);
        rst_n = 1'b1;
        quiet(5);
        t_reset();
        t_full_width();
        t_narrow();
        t_clamp();
        t_loop();
        t_gap();
        t_armed_rise();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule